// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block is a purely combinational 16-bit two's-complement adder and subtractor. It takes two operands, an external carry-in and a mode select, and returns the 16-bit result, the unsigned carry-out and a signed overflow flag. No clock or storage is involved, so the outputs follow the inputs within the same cycle.

The operand width is split into four 4-bit slices. Each slice forms per-bit generate and propagate terms. It computes its internal carries as flat sum-of-products expressions from its own carry-in, so no carry passes from one bit to the next. Each slice also reports a slice-level generate and propagate pair. A second-level lookahead network uses the same flat expansion over the four slice pairs to form every slice carry-in and the final carry-out directly from the block carry-in.

Subtraction is done by complementing the second operand and forcing the carry-in to one. A small control module turns the mode select into two strobes that it hands to the datapath.

Top module: `cla16_top`

## Requirements
- R1: With `subMode`=0, `{carryOut, result}` equals the 17-bit unsigned sum `opA + opB + carryIn`.
- R2: With `subMode`=1, `result` equals `opA - opB` modulo 2^16, and `carryOut` equals the carry of `opA + ~opB + 1`. This carry is 1 exactly when `opA >= opB` as unsigned values. `carryIn` has no effect on any output in this mode.
- R3: The carry into each 4-bit slice k (bits 4k..4k+3) equals the carry out of the low 4k bits of the effective addition. The second-level network forms it from the slice generate/propagate pairs and the effective carry-in. A full-propagate pattern, such as 0x5555 + 0xAAAA with carry-in 1, therefore gives result 0x0000 and carryOut 1.
- R4: `carryOut` is the carry out of bit 15 of the effective addition.
- R5: `overflow` is 1 exactly when the carry into bit 15 differs from the carry out of bit 15. This is the same as saying that opA and the effective second operand share a sign bit and the result has the other sign bit.
- R6: 0x7FFF + 0x0001 (add, carryIn 0) gives 0x8000 with overflow 1. 0x8000 - 0x0001 gives 0x7FFF with overflow 1.
- R7: 0xFFFF + 0x0001 (add, carryIn 0) gives 0x0000 with carryOut 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand (minuend in subtract mode) |
| opB | input | 16 | Second operand (subtrahend in subtract mode) |
| carryIn | input | 1 | Carry-in for add mode; ignored in subtract mode |
| subMode | input | 1 | 0 = add, 1 = subtract |
| result | output | 16 | Sum or difference |
| carryOut | output | 1 | Carry out of bit 15 |
| overflow | output | 1 | Signed overflow flag |

## Verification
The checks assume that all four inputs hold known 0/1 values. They also assume that the block sees those inputs long enough for the combinational paths to settle. Each check is skipped while any input is unknown. The bench changes inputs only on the falling clock edge and observes outputs at the next rising edge, which gives the logic half a period to settle. The stimulus covers every pair drawn from a set of sign-boundary and carry-chain operand values, in both modes and with both carry-in values, and then adds a few thousand pseudo-random vectors.

// File: rtl/cla16_pkg.sv
package cla16_pkg;
  localparam int DATA_W  = 16;
  localparam int GRP_W   = 4;
  localparam int NUM_GRP = DATA_W / GRP_W;

  typedef struct packed {
    logic invertOperand;  // complement second operand
    logic effCarry;       // carry fed into the lookahead tree
  } ctrlStrobe_t;
endpackage

// File: rtl/cla_carry_net.sv
// Flat sum-of-products lookahead: every carry is built from the base
// carry-in and the gen/prp vector, with no carry chained between positions.
module cla_carry_net #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prp,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         blkGen,
  output logic         blkPrp
);
  logic acc;
  logic term;

  always_comb begin
    carry[0] = cin;
    acc  = 1'b0;
    term = 1'b0;
    for (int j = 1; j <= N; j++) begin
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = gen[k];
        for (int m = k + 1; m < j; m++) term = term & prp[m];
        acc = acc | term;
      end
      term = cin;
      for (int m = 0; m < j; m++) term = term & prp[m];
      carry[j] = acc | term;
    end
  end

  always_comb begin
    blkGen = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic t;
      t = gen[k];
      for (int m = k + 1; m < N; m++) t = t & prp[m];
      blkGen = blkGen | t;
    end
  end

  assign blkPrp = &prp;
endmodule

// File: rtl/cla_group.sv
// One slice: bit-level gen/prp, local flat carries, sum, slice gen/prp.
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  input  logic         cin,
  output logic [W-1:0] sumOut,
  output logic         grpGen,
  output logic         grpPrp,
  output logic         msbCarryIn
);
  logic [W-1:0] bitGen;
  logic [W-1:0] bitPrp;
  logic [W:0]   localCarry;
  logic         unusedTop;

  assign bitGen = xIn & yIn;
  assign bitPrp = xIn ^ yIn;

  cla_carry_net #(.N(W)) net_i (
    .gen    (bitGen),
    .prp    (bitPrp),
    .cin    (cin),
    .carry  (localCarry),
    .blkGen (grpGen),
    .blkPrp (grpPrp)
  );

  assign sumOut     = bitPrp ^ localCarry[W-1:0];
  assign msbCarryIn = localCarry[W-1];
  assign unusedTop  = localCarry[W];
endmodule

// File: rtl/cla16_ctrl.sv
module cla16_ctrl
  import cla16_pkg::*;
(
  input  logic        subMode,
  input  logic        carryIn,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.invertOperand = subMode;
    strobe.effCarry      = subMode ? 1'b1 : carryIn;
  end
endmodule

// File: rtl/cla16_datapath.sv
module cla16_datapath
  import cla16_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflow,
  output logic [NUM_GRP:0]  groupCarry
);
  logic [DATA_W-1:0]  opBEff;
  logic [NUM_GRP-1:0] sliceGen;
  logic [NUM_GRP-1:0] slicePrp;
  logic [NUM_GRP-1:0] sliceMsbC;
  logic               treeGen;
  logic               treePrp;

  assign opBEff = strobe.invertOperand ? ~opB : opB;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gSlice
    cla_group #(.W(GRP_W)) grp_i (
      .xIn        (opA[g*GRP_W +: GRP_W]),
      .yIn        (opBEff[g*GRP_W +: GRP_W]),
      .cin        (groupCarry[g]),
      .sumOut     (result[g*GRP_W +: GRP_W]),
      .grpGen     (sliceGen[g]),
      .grpPrp     (slicePrp[g]),
      .msbCarryIn (sliceMsbC[g])
    );
  end

  cla_carry_net #(.N(NUM_GRP)) tree_i (
    .gen    (sliceGen),
    .prp    (slicePrp),
    .cin    (strobe.effCarry),
    .carry  (groupCarry),
    .blkGen (treeGen),
    .blkPrp (treePrp)
  );

  assign carryOut = groupCarry[NUM_GRP];
  assign overflow = sliceMsbC[NUM_GRP-1] ^ groupCarry[NUM_GRP];
endmodule

// File: rtl/cla16_top.sv
module cla16_top
  import cla16_pkg::*;
(
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic        carryIn,
  input  logic        subMode,
  output logic [15:0] result,
  output logic        carryOut,
  output logic        overflow
);
  ctrlStrobe_t        strobe;
  logic [NUM_GRP:0]   groupCarry;

  cla16_ctrl ctrl_i (
    .subMode (subMode),
    .carryIn (carryIn),
    .strobe  (strobe)
  );

  cla16_datapath dp_i (
    .opA        (opA),
    .opB        (opB),
    .strobe     (strobe),
    .result     (result),
    .carryOut   (carryOut),
    .overflow   (overflow),
    .groupCarry (groupCarry)
  );
endmodule

// File: rtl/cla16_checker.sv
module cla16_checker
  import cla16_pkg::*;
(
  input logic [15:0]        opA,
  input logic [15:0]        opB,
  input logic               carryIn,
  input logic               subMode,
  input logic [15:0]        result,
  input logic               carryOut,
  input logic               overflow,
  input logic [NUM_GRP:0]   groupCarry
);
  logic [15:0] bEff;
  logic        cEff;
  logic [16:0] wide;
  logic        known;

  always_comb begin
    bEff  = subMode ? ~opB : opB;
    cEff  = subMode ? 1'b1 : carryIn;
    wide  = {1'b0, opA} + {1'b0, bEff} + {16'd0, cEff};
    known = !$isunknown({opA, opB, carryIn, subMode});
    if (known) begin
      // R1 / R2: arithmetic result
      a_r1_sum: assert ({carryOut, result} == wide)
        else $error("a_r1_sum: got %h exp %h", {carryOut, result}, wide);
      if (subMode) begin
        a_r2_diff: assert (result == 16'(opA - opB))
          else $error("a_r2_diff: got %h", result);
        a_r2_borrow: assert (carryOut == (opA >= opB))
          else $error("a_r2_borrow: got %b", carryOut);
      end
      // R3: each slice carry equals carry out of the low bits
      for (int k = 1; k < NUM_GRP; k++) begin
        logic [16:0] part;
        part = ({1'b0, opA} & ((17'd1 << (k*GRP_W)) - 17'd1))
             + ({1'b0, bEff} & ((17'd1 << (k*GRP_W)) - 17'd1))
             + {16'd0, cEff};
        a_r3_group_carry: assert (groupCarry[k] == part[k*GRP_W])
          else $error("a_r3_group_carry: slice %0d", k);
      end
      a_r3_base_carry: assert (groupCarry[0] == cEff)
        else $error("a_r3_base_carry");
      // R5: overflow by sign comparison
      a_r5_overflow: assert (overflow ==
          ((opA[15] == bEff[15]) && (result[15] != opA[15])))
        else $error("a_r5_overflow: got %b", overflow);
    end
  end
endmodule

bind cla16_top cla16_checker chk_i (
  .opA        (opA),
  .opB        (opB),
  .carryIn    (carryIn),
  .subMode    (subMode),
  .result     (result),
  .carryOut   (carryOut),
  .overflow   (overflow),
  .groupCarry (groupCarry)
);

// File: tb/cla16_tb.sv
`timescale 1ns/1ps
module cla16_top_tb_top;
  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic        subMode = 1'b0;
  logic [15:0] result;
  logic        carryOut;
  logic        overflow;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cla16_top dut_i (
    .opA (opA), .opB (opB), .carryIn (carryIn), .subMode (subMode),
    .result (result), .carryOut (carryOut), .overflow (overflow)
  );

  task automatic checkVal(string tag, string what, logic [16:0] got, logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s a=%h b=%h cin=%b sub=%b actual=%h expected=%h",
               tag, what, opA, opB, carryIn, subMode, got, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b, logic c, logic s);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; subMode = s;
    @(posedge clk);
  endtask

  // Expected values from the requirements: R1/R2 for the sum, R4 carry, R5 overflow
  task automatic runVec(logic [15:0] a, logic [15:0] b, logic c, logic s);
    logic [15:0] be;
    logic        ce;
    logic [16:0] w;
    logic        ov;
    apply(a, b, c, s);
    be = s ? ~b : b;
    ce = s ? 1'b1 : c;
    w  = {1'b0, a} + {1'b0, be} + {16'd0, ce};
    ov = (a[15] == be[15]) && (w[15] != a[15]);
    checkVal(s ? "R2" : "R1", "result", {1'b0, result}, {1'b0, w[15:0]});
    checkVal("R4", "carryOut", {16'd0, carryOut}, {16'd0, w[16]});
    checkVal("R5", "overflow", {16'd0, overflow}, {16'd0, ov});
  endtask

  initial begin
    logic [15:0] edges [10];
    logic [15:0] keepRes;
    logic        keepC;
    logic        keepO;
    edges = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
              16'hFFFE, 16'h000F, 16'h00F0, 16'h5555, 16'hAAAA};

    // reset-state style check: all-zero inputs give zero outputs
    apply(16'h0000, 16'h0000, 1'b0, 1'b0);
    checkVal("R1", "idle result", {carryOut, result}, 17'h0);
    checkVal("R5", "idle overflow", {16'd0, overflow}, 17'h0);

    // R6 corner cases
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0);
    checkVal("R6", "max+1 result", {1'b0, result}, 17'h08000);
    checkVal("R6", "max+1 overflow", {16'd0, overflow}, 17'h1);
    apply(16'h8000, 16'h0001, 1'b0, 1'b1);
    checkVal("R6", "min-1 result", {1'b0, result}, 17'h07FFF);
    checkVal("R6", "min-1 overflow", {16'd0, overflow}, 17'h1);

    // R7 wrap with carry
    apply(16'hFFFF, 16'h0001, 1'b0, 1'b0);
    checkVal("R7", "wrap result", {1'b0, result}, 17'h0);
    checkVal("R7", "wrap carry", {16'd0, carryOut}, 17'h1);
    checkVal("R7", "wrap overflow", {16'd0, overflow}, 17'h0);

    // R3 full propagate through every slice
    apply(16'h5555, 16'hAAAA, 1'b1, 1'b0);
    checkVal("R3", "propagate chain", {carryOut, result}, 17'h10000);
    apply(16'h5555, 16'hAAAA, 1'b0, 1'b0);
    checkVal("R3", "propagate no cin", {carryOut, result}, 17'h0FFFF);

    // R2 carryIn ignored in subtract mode
    apply(16'h1234, 16'h0235, 1'b0, 1'b1);
    keepRes = result; keepC = carryOut; keepO = overflow;
    apply(16'h1234, 16'h0235, 1'b1, 1'b1);
    checkVal("R2", "cin ignored", {overflow, carryOut, result[14:0]},
             {keepO, keepC, keepRes[14:0]});
    checkVal("R2", "cin ignored msb", {16'd0, result[15]}, {16'd0, keepRes[15]});
    checkVal("R2", "difference", {1'b0, result}, 17'h00FFF);

    // sweep of every edge pair, both modes, both carry-in values
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int m = 0; m < 4; m++)
          runVec(edges[i], edges[j], m[0], m[1]);

    // pseudo-random vectors
    for (int n = 0; n < 4000; n++)
      runVec(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule